// File: doc/BRIEF.md
# Fractional-Rate Sample Address Generator

This block produces the byte addresses for one playback channel that reads sample data from memory. A 16-bit rate word is added into a 16-bit phase accumulator on every base-rate enable. Each carry out of the accumulator makes one fetch strobe and advances a byte pointer. The pointer runs through a window of 256-byte pages set by a first page and a last page. The fetch rate is therefore the base rate scaled by rate/65536.

When the pointer reaches the last byte of the last page, one of two things happens. If looping is enabled, it returns to the first byte of the first page and playback continues. Otherwise playback halts and a sticky end flag is raised. The end flag is cleared only by a dedicated clear input.

Panning enables and an 8-bit output level are held in registers and passed straight to outputs for the audio path downstream. All settings are written through a byte-wide write port with a 4-bit register select.

Top module: `dn_fetch_gen`

## Requirements
- R1: After reset, `playing`, `end_flag`, `fetch_stb`, `fetch_addr`, `left_en`, `right_en` and `level` are all zero.
- R2: A write to select 1 sets `left_en` from data bit 0 and `right_en` from data bit 1. A write to select 8 sets `level`, where 8'hFF is the loudest. The new values show one cycle after the write.
- R3: A write to select 0 latches the run bit (data bit 0) and the loop bit (data bit 1). If data bit 7 is set, both run and loop are forced to 0 and bits 0 and 1 are ignored, so no playback starts.
- R4: A write to select 0 that takes the run bit from 0 to 1 clears the accumulator and loads the pointer with {first page, 8'h00}. It raises `playing` at the same edge. The first strobe then presents that address.
- R5: The first page is written at select 2 (low byte) and select 3 (high byte). The last page is written at selects 4 and 5. The rate is written at select 6 (low byte) and select 7 (high byte). While playing, each cycle with `rate_tick` adds the rate to the accumulator. A carry out of bit 15 gives exactly one cycle of `fetch_stb`, with `fetch_addr` holding the pointer value, and the pointer then increments. A rate of 0 never produces a strobe.
- R6: At a strobe whose address is {last page, 8'hFF} with loop set, the pointer returns to {first page, 8'h00}. `playing` stays high and `end_flag` is not raised.
- R7: At a strobe whose address is {last page, 8'hFF} with loop clear, `playing` falls and `end_flag` rises at the same edge as that strobe. No further strobes follow.
- R8: `end_flag` stays set until `flag_clr` is high at a clock edge. If a new end event and `flag_clr` fall on the same edge, the flag stays set.
- R9: A write to select 0 with run bit 0, or with bit 7 set, drops `playing` at that edge. No strobe is issued in that cycle.
- R10: Writes to selects 9 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register select |
| wr_data | input | 8 | Register write data |
| rate_tick | input | 1 | Base-rate enable |
| flag_clr | input | 1 | Clears the end flag |
| fetch_addr | output | 24 | Byte address of the current fetch |
| fetch_stb | output | 1 | One-cycle fetch request |
| playing | output | 1 | Channel is running |
| end_flag | output | 1 | Sticky end-of-window flag |
| left_en | output | 1 | Left output enable |
| right_en | output | 1 | Right output enable |
| level | output | 8 | Output level, 8'hFF loudest |

## Verification
The assertions assume that every input is known at each rising edge once reset is released. They also assume that a start can only come from a control write, so `playing` has no other way to rise. The stimulus drives every input on the falling clock edge and holds all inputs idle during reset. It changes the control register only through single-cycle writes, so each start, halt and loop decision is tied to exactly one edge. Rate enables are applied both as continuous runs and as sparse pulses, which keeps the carry pattern consistent with the accumulator's single-step behaviour.

// File: rtl/dn_fetch_pkg.sv
package dn_fetch_pkg;

    localparam int SEL_W = 4;

    typedef enum logic [SEL_W-1:0] {
        REG_CTRL    = 4'h0,
        REG_PAN     = 4'h1,
        REG_BEG_LO  = 4'h2,
        REG_BEG_HI  = 4'h3,
        REG_END_LO  = 4'h4,
        REG_END_HI  = 4'h5,
        REG_RATE_LO = 4'h6,
        REG_RATE_HI = 4'h7,
        REG_LEVEL   = 4'h8
    } reg_sel_e;

    localparam int CTRL_RUN   = 0;
    localparam int CTRL_LOOP  = 1;
    localparam int CTRL_CLEAR = 7;
    localparam int PAN_LEFT   = 0;
    localparam int PAN_RIGHT  = 1;

endpackage

// File: rtl/dn_regs.sv
module dn_regs
    import dn_fetch_pkg::*;
#(
    parameter int PAGE_W = 16,
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_addr,
    input  logic [7:0]        wr_data,
    output logic              loop_o,
    output logic              left_o,
    output logic              right_o,
    output logic [7:0]        level_o,
    output logic [PAGE_W-1:0] beg_page_o,
    output logic [PAGE_W-1:0] end_page_o,
    output logic [RATE_W-1:0] rate_o,
    output logic              go_o,
    output logic              halt_o
);

    typedef struct packed {
        logic              run;
        logic              loop;
        logic              left;
        logic              right;
        logic [7:0]        level;
        logic [PAGE_W-1:0] beg;
        logic [PAGE_W-1:0] fin;
        logic [RATE_W-1:0] rate;
    } regs_t;

    regs_t r_d, r_q;
    logic  go_d, halt_d;

    always_comb begin
        r_d    = r_q;
        go_d   = 1'b0;
        halt_d = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                REG_CTRL: begin
                    if (wr_data[CTRL_CLEAR]) begin
                        r_d.run  = 1'b0;
                        r_d.loop = 1'b0;
                        halt_d   = 1'b1;
                    end else begin
                        r_d.run  = wr_data[CTRL_RUN];
                        r_d.loop = wr_data[CTRL_LOOP];
                        go_d     = wr_data[CTRL_RUN] & ~r_q.run;
                        halt_d   = ~wr_data[CTRL_RUN];
                    end
                end
                REG_PAN: begin
                    r_d.left  = wr_data[PAN_LEFT];
                    r_d.right = wr_data[PAN_RIGHT];
                end
                REG_BEG_LO:  r_d.beg[7:0]         = wr_data;
                REG_BEG_HI:  r_d.beg[PAGE_W-1:8]  = wr_data[PAGE_W-9:0];
                REG_END_LO:  r_d.fin[7:0]         = wr_data;
                REG_END_HI:  r_d.fin[PAGE_W-1:8]  = wr_data[PAGE_W-9:0];
                REG_RATE_LO: r_d.rate[7:0]        = wr_data;
                REG_RATE_HI: r_d.rate[RATE_W-1:8] = wr_data[RATE_W-9:0];
                REG_LEVEL:   r_d.level            = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign loop_o     = r_q.loop;
    assign left_o     = r_q.left;
    assign right_o    = r_q.right;
    assign level_o    = r_q.level;
    assign beg_page_o = r_q.beg;
    assign end_page_o = r_q.fin;
    assign rate_o     = r_q.rate;
    assign go_o       = go_d;
    assign halt_o     = halt_d;

endmodule

// File: rtl/dn_phase_acc.sv
module dn_phase_acc #(
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [RATE_W-1:0] rate,
    output logic              carry_o
);

    typedef struct packed {
        logic [RATE_W-1:0] acc;
    } acc_t;

    acc_t        a_d, a_q;
    logic [RATE_W:0] sum;

    always_comb begin
        a_d = a_q;
        sum = {1'b0, a_q.acc} + {1'b0, rate};
        if (clr)     a_d.acc = '0;
        else if (en) a_d.acc = sum[RATE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign carry_o = en & sum[RATE_W];

endmodule

// File: rtl/dn_addr_step.sv
module dn_addr_step #(
    parameter int PAGE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              halt,
    input  logic              carry,
    input  logic              loop,
    input  logic              flag_clr,
    input  logic [PAGE_W-1:0] beg_page,
    input  logic [PAGE_W-1:0] end_page,
    output logic              run_o,
    output logic              stb_o,
    output logic              flag_o,
    output logic [PAGE_W+7:0] addr_o
);

    localparam int ADDR_W = PAGE_W + 8;

    typedef struct packed {
        logic              run;
        logic              stb;
        logic              flag;
        logic [ADDR_W-1:0] ptr;
        logic [ADDR_W-1:0] out;
    } step_t;

    step_t s_d, s_q;
    logic  at_last;

    always_comb begin
        s_d     = s_q;
        s_d.stb = 1'b0;
        at_last = (s_q.ptr == {end_page, 8'hFF});
        if (flag_clr) s_d.flag = 1'b0;
        if (go) begin
            s_d.ptr = {beg_page, 8'h00};
            s_d.run = 1'b1;
        end else if (halt) begin
            s_d.run = 1'b0;
        end else if (carry) begin
            s_d.stb = 1'b1;
            s_d.out = s_q.ptr;
            if (at_last) begin
                if (loop) begin
                    s_d.ptr = {beg_page, 8'h00};
                end else begin
                    s_d.run  = 1'b0;
                    s_d.flag = 1'b1;
                end
            end else begin
                s_d.ptr = s_q.ptr + ADDR_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign run_o  = s_q.run;
    assign stb_o  = s_q.stb;
    assign flag_o = s_q.flag;
    assign addr_o = s_q.out;

endmodule

// File: rtl/dn_fetch_gen.sv
module dn_fetch_gen
    import dn_fetch_pkg::*;
#(
    parameter int PAGE_W = 16,
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              rate_tick,
    input  logic              flag_clr,
    output logic [PAGE_W+7:0] fetch_addr,
    output logic              fetch_stb,
    output logic              playing,
    output logic              end_flag,
    output logic              left_en,
    output logic              right_en,
    output logic [7:0]        level
);

    logic              loop_q, go, halt, carry;
    logic [PAGE_W-1:0] beg_page, end_page;
    logic [RATE_W-1:0] rate;

    dn_regs #(.PAGE_W(PAGE_W), .RATE_W(RATE_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .loop_o     (loop_q),
        .left_o     (left_en),
        .right_o    (right_en),
        .level_o    (level),
        .beg_page_o (beg_page),
        .end_page_o (end_page),
        .rate_o     (rate),
        .go_o       (go),
        .halt_o     (halt)
    );

    dn_phase_acc #(.RATE_W(RATE_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (go),
        .en      (playing & rate_tick),
        .rate    (rate),
        .carry_o (carry)
    );

    dn_addr_step #(.PAGE_W(PAGE_W)) u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .halt     (halt),
        .carry    (carry),
        .loop     (loop_q),
        .flag_clr (flag_clr),
        .beg_page (beg_page),
        .end_page (end_page),
        .run_o    (playing),
        .stb_o    (fetch_stb),
        .flag_o   (end_flag),
        .addr_o   (fetch_addr)
    );

endmodule

// File: rtl/dn_fetch_gen_chk.sv
module dn_fetch_gen_chk
    import dn_fetch_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [3:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       rate_tick,
    input logic       flag_clr,
    input logic       fetch_stb,
    input logic       playing,
    input logic       end_flag
);

    // R5
    stb_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stb |-> $past(rate_tick && playing));

    // R7
    stop_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(end_flag) |-> (!playing && fetch_stb));

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(end_flag) |-> $past(flag_clr));

    // R4
    start_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(playing) |-> $past(wr_en && wr_addr == REG_CTRL
                                 && wr_data[CTRL_RUN] && !wr_data[CTRL_CLEAR]));

    // R9
    halt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_CTRL && (!wr_data[CTRL_RUN] || wr_data[CTRL_CLEAR]))
        |=> !playing);

endmodule

bind dn_fetch_gen dn_fetch_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rate_tick (rate_tick),
    .flag_clr  (flag_clr),
    .fetch_stb (fetch_stb),
    .playing   (playing),
    .end_flag  (end_flag)
);

// File: tb/dn_fetch_gen_test.sv
`timescale 1ns/1ps
module dn_fetch_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        rate_tick = 1'b0;
    logic        flag_clr = 1'b0;
    logic [23:0] fetch_addr;
    logic        fetch_stb, playing, end_flag, left_en, right_en;
    logic [7:0]  level;

    dn_fetch_gen uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rate_tick(rate_tick), .flag_clr(flag_clr),
        .fetch_addr(fetch_addr), .fetch_stb(fetch_stb), .playing(playing),
        .end_flag(end_flag), .left_en(left_en), .right_en(right_en), .level(level)
    );

    always #10 clk = ~clk;

    int errs = 0, checks = 0;
    bit cmp_on = 0;
    int stb_cnt = 0, base_hits = 0;

    // behavioural reference state
    bit m_runbit, m_loop, m_left, m_right, m_play, m_stb, m_flag;
    int m_level, m_beg, m_fin, m_rate, m_acc, m_ptr, m_out;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    always @(posedge clk) begin : ref_model
        bit go, halt, carry;
        int sum;
        if (!rst_n) begin
            m_runbit = 0; m_loop = 0; m_left = 0; m_right = 0; m_play = 0;
            m_stb = 0; m_flag = 0; m_level = 0; m_beg = 0; m_fin = 0;
            m_rate = 0; m_acc = 0; m_ptr = 0; m_out = 0;
        end else begin
            go = 0; halt = 0;
            if (wr_en && wr_addr == 4'h0) begin
                if (wr_data[7]) halt = 1;
                else begin
                    go   = wr_data[0] && !m_runbit;
                    halt = !wr_data[0];
                end
            end
            sum   = m_acc + m_rate;
            carry = m_play && rate_tick && (sum >= 65536);
            if (m_play && rate_tick) m_acc = sum % 65536;
            m_stb = 0;
            if (flag_clr) m_flag = 0;
            if (go) begin
                m_acc = 0; m_ptr = m_beg * 256; m_play = 1;
            end else if (halt) begin
                m_play = 0;
            end else if (carry) begin
                m_stb = 1; m_out = m_ptr;
                if (m_ptr == m_fin * 256 + 255) begin
                    if (m_loop) m_ptr = m_beg * 256;
                    else begin m_play = 0; m_flag = 1; end
                end else m_ptr = (m_ptr + 1) % (1 << 24);
            end
            if (wr_en) begin
                case (wr_addr)
                    4'h0: begin
                        m_runbit = wr_data[7] ? 1'b0 : wr_data[0];
                        m_loop   = wr_data[7] ? 1'b0 : wr_data[1];
                    end
                    4'h1: begin m_left = wr_data[0]; m_right = wr_data[1]; end
                    4'h2: m_beg  = (m_beg  & 32'hFF00) | int'(wr_data);
                    4'h3: m_beg  = (m_beg  & 32'h00FF) | (int'(wr_data) << 8);
                    4'h4: m_fin  = (m_fin  & 32'hFF00) | int'(wr_data);
                    4'h5: m_fin  = (m_fin  & 32'h00FF) | (int'(wr_data) << 8);
                    4'h6: m_rate = (m_rate & 32'hFF00) | int'(wr_data);
                    4'h7: m_rate = (m_rate & 32'h00FF) | (int'(wr_data) << 8);
                    4'h8: m_level = int'(wr_data);
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (fetch_stb) begin
            stb_cnt++;
            if (fetch_addr == 24'h001000) base_hits++;
        end
        if (cmp_on) begin
            chk(fetch_stb == m_stb, "R5 fetch_stb", int'(fetch_stb), int'(m_stb));
            chk(int'(fetch_addr) == m_out, "R5 fetch_addr", int'(fetch_addr), m_out);
            chk(playing == m_play, "R4 playing", int'(playing), int'(m_play));
            chk(end_flag == m_flag, "R7 end_flag", int'(end_flag), int'(m_flag));
            chk(left_en == m_left && right_en == m_right, "R2 pan",
                int'({left_en, right_en}), int'({m_left, m_right}));
            chk(int'(level) == m_level, "R2 level", int'(level), m_level);
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick_run(input int n);
        @(negedge clk);
        rate_tick = 1'b1;
        repeat (n) @(negedge clk);
        rate_tick = 1'b0;
    endtask

    task automatic tick_sparse(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); rate_tick = 1'b1;
            @(negedge clk); rate_tick = 1'b0;
            repeat (gap) @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++; errs++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin : stim
        int s0, h0;
        idle(4);
        rst_n = 1'b1;
        idle(1);
        cmp_on = 1;
        // R1 reset state
        expect_eq("R1 playing", int'(playing), 0);
        expect_eq("R1 end_flag", int'(end_flag), 0);
        expect_eq("R1 fetch_stb", int'(fetch_stb), 0);
        expect_eq("R1 fetch_addr", int'(fetch_addr), 0);
        expect_eq("R1 level", int'(level), 0);

        // R2 pan and level
        wr(4'h1, 8'h03);
        wr(4'h8, 8'hFF);
        expect_eq("R2 left", int'(left_en), 1);
        expect_eq("R2 right", int'(right_en), 1);
        expect_eq("R2 level", int'(level), 255);
        wr(4'h1, 8'h02);
        expect_eq("R2 left off", int'(left_en), 0);

        // R10 unmapped selects
        wr(4'hF, 8'h5A);
        wr(4'h9, 8'h00);
        wr(4'hC, 8'h01);
        expect_eq("R10 level kept", int'(level), 255);
        expect_eq("R10 pan kept", int'({left_en, right_en}), 1);
        expect_eq("R10 no start", int'(playing), 0);

        // R3 clear bit overrides run
        wr(4'h0, 8'h83);
        expect_eq("R3 clear blocks start", int'(playing), 0);

        // R4/R7 single page, no loop, rate 1/2
        wr(4'h2, 8'h10); wr(4'h3, 8'h00);
        wr(4'h4, 8'h10); wr(4'h5, 8'h00);
        wr(4'h6, 8'h00); wr(4'h7, 8'h80);
        s0 = stb_cnt; h0 = base_hits;
        wr(4'h0, 8'h01);
        expect_eq("R4 playing after start", int'(playing), 1);
        tick_run(600);
        idle(2);
        expect_eq("R7 strobes in window", stb_cnt - s0, 256);
        expect_eq("R4 first address once", base_hits - h0, 1);
        expect_eq("R7 stopped", int'(playing), 0);
        expect_eq("R7 flag set", int'(end_flag), 1);
        expect_eq("R7 last address", int'(fetch_addr), 24'h0010FF);

        // R8 sticky then cleared
        idle(5);
        expect_eq("R8 flag sticky", int'(end_flag), 1);
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        expect_eq("R8 flag cleared", int'(end_flag), 0);

        // R6 looping with rate FFFF
        wr(4'h0, 8'h00);
        wr(4'h6, 8'hFF); wr(4'h7, 8'hFF);
        s0 = stb_cnt; h0 = base_hits;
        wr(4'h0, 8'h03);
        tick_run(300);
        idle(2);
        expect_eq("R6 wrapped to first byte", base_hits - h0, 2);
        expect_eq("R6 strobe count", stb_cnt - s0, 299);
        expect_eq("R6 still playing", int'(playing), 1);
        expect_eq("R6 no end flag", int'(end_flag), 0);

        // R9 halt while ticking
        @(negedge clk); rate_tick = 1'b1;
        idle(3);
        wr_en = 1'b1; wr_addr = 4'h0; wr_data = 8'h00;
        @(negedge clk); wr_en = 1'b0;
        expect_eq("R9 halted", int'(playing), 0);
        s0 = stb_cnt;
        idle(20);
        rate_tick = 1'b0;
        expect_eq("R9 no strobes after halt", stb_cnt - s0, 0);

        // R5 zero rate
        wr(4'h6, 8'h00); wr(4'h7, 8'h00);
        s0 = stb_cnt;
        wr(4'h0, 8'h01);
        tick_run(50);
        idle(2);
        expect_eq("R5 zero rate no strobe", stb_cnt - s0, 0);
        expect_eq("R5 zero rate playing", int'(playing), 1);

        // R5 sparse ticks, rate 5555, new window
        wr(4'h0, 8'h00);
        wr(4'h2, 8'h00); wr(4'h3, 8'h02);
        wr(4'h4, 8'h10); wr(4'h5, 8'h02);
        wr(4'h6, 8'h55); wr(4'h7, 8'h55);
        s0 = stb_cnt;
        wr(4'h0, 8'h01);
        tick_sparse(30, 2);
        idle(2);
        expect_eq("R5 fractional strobe count", stb_cnt - s0, 9);
        expect_eq("R5 latest address", int'(fetch_addr), 24'h020008);

        idle(3);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule